// File: doc/BRIEF.md
# Memory Self-Test Pattern Engine

This block runs a built-in test of an external memory. Software programs a run: single or burst access, a write pass or a read-and-compare pass, one of four data patterns, the number of beats in each burst and a 32-bit burst count. It then pulses `start`. The engine walks the address space upward from word 0, one word per beat. In a write pass it writes the chosen pattern. In a read pass it regenerates the same pattern and compares it with each returned word.

Mismatches go into an error counter that saturates instead of wrapping. Software reads this counter as a 16-bit low half and a 15-bit high half. A sticky end flag reports that the run is over. A normal test is a write pass followed by a read pass with the same pattern and the same geometry.

The memory side has a command channel using valid/ready. The command payload is an address, a write flag, write data and a last-of-burst marker. The payload holds steady while valid is high and ready is low, so the memory can apply back-pressure on every beat. Read data comes back in order on a return channel that has a valid and no ready. That channel cannot be stalled, because the memory answers with a fixed latency.

Top module: `memtest_engine`

## Requirements
- R1: After reset, `busy`, `end_flag` and `mem_valid` are 0 and both error-count halves are 0.
- R2: A `start` seen while idle latches every configuration input, clears the error count and clears `end_flag`. While `busy` is 1, `start` and changes on the configuration inputs have no effect on the run in progress.
- R3: The first command of a run uses address 0, and each accepted command raises the address by one. `mem_write` is 1 in every command of a run started with `cfg_read`=0 and 0 in every command of a run started with `cfg_read`=1.
- R4: The pattern select chooses the write data and the compare data. Value 0 gives 32'haaaa5555, value 1 gives 32'hffffffff, value 2 gives 32'ha5a55a5a, and value 3 gives the word index within the run, counting from 0.
- R5: A run issues exactly bursts × beats commands. The burst count is {`cfg_bursts_hi`,`cfg_bursts_lo`}. A beat count of 0 is treated as 1. A burst count of 0 ends the run with no command issued.
- R6: With `cfg_burst_mode`=1, `mem_last` is 1 on the final beat of each burst and 0 on the other beats. With `cfg_burst_mode`=0, `mem_last` is 1 on every command.
- R7: In single mode (`cfg_burst_mode`=0), a read command is issued only after the data of the previous read has returned. In burst mode, reads are issued back to back.
- R8: Once `mem_valid` is 1, it stays 1 with an unchanged payload until `mem_ready` is 1.
- R9: In a read pass, each returned word is compared in order with the regenerated pattern word. Each mismatch adds one to the error count.
- R10: The error count stops at 2^ERR_W−1 and does not wrap. Bits 15:0 appear on `err_cnt_lo` and bits 30:16 on `err_cnt_hi`.
- R11: `end_flag` rises once all commands are accepted and all read data has returned. `busy` is then 0, and `end_flag` stays 1 until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_mode | input | 1 | 0 single access, 1 burst access |
| cfg_read | input | 1 | 0 write pass, 1 read-and-compare pass |
| cfg_pattern | input | 2 | Pattern select |
| cfg_max_beats | input | 8 | Beats per burst (0 means 1) |
| cfg_bursts_lo | input | 16 | Burst count, low half |
| cfg_bursts_hi | input | 16 | Burst count, high half |
| start | input | 1 | Launch one run when idle |
| busy | output | 1 | Run in progress |
| end_flag | output | 1 | Sticky run-complete flag |
| err_cnt_lo | output | 16 | Error count bits 15:0 |
| err_cnt_hi | output | 15 | Error count bits 30:16 |
| mem_valid | output | 1 | Command valid |
| mem_ready | input | 1 | Command accepted by memory |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_last | output | 1 | Last beat of a burst |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |

## Verification
The assertions assume three things about the memory. It returns exactly one read word for each accepted read command, never sends `rd_valid` with no read outstanding, and keeps fewer than 2^OUT_W reads in flight. The bench memory model meets all three: it answers every accepted read after a fixed three-cycle delay and sends nothing else. It also drives `mem_ready` from a pseudo-random sequence, so every beat can be back-pressured. All runs except the long burst-count run stay within 64 words, so the model's 64-word array never aliases during a read pass.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    PAT_AA55 = 2'd0,
    PAT_ONES = 2'd1,
    PAT_A5   = 2'd2,
    PAT_INC  = 2'd3
  } pat_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN
  } state_e;

  function automatic logic [31:0] pattern_word(pat_e sel, logic [31:0] idx);
    case (sel)
      PAT_AA55: return 32'haaaa5555;
      PAT_ONES: return 32'hffffffff;
      PAT_A5:   return 32'ha5a55a5a;
      default:  return idx;
    endcase
  endfunction

endpackage

// File: rtl/memtest_pattern.sv
module memtest_pattern
  import memtest_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [1:0]  sel_in,
  input  logic        adv,
  output logic [31:0] word
);

  pat_e        sel_q;
  logic [31:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= PAT_AA55;
      idx_q <= '0;
    end else if (load) begin
      sel_q <= pat_e'(sel_in);
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= idx_q + 32'd1;
    end
  end

  assign word = pattern_word(sel_q, idx_q);

endmodule

// File: rtl/memtest_errcnt.sv
module memtest_errcnt #(
  parameter int ERR_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic [31:0]      actual,
  input  logic [31:0]      expected,
  output logic [ERR_W-1:0] count
);

  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

  logic miss;
  assign miss = sample && (actual != expected);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (miss && count != CNT_MAX) count <= count + ERR_W'(1);
  end

  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !sample) |=> $stable(count));

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int BEAT_W  = 8,
  parameter int BURST_W = 32,
  parameter int OUT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_burst_mode,
  input  logic               cfg_read,
  input  logic [BEAT_W-1:0]  cfg_max_beats,
  input  logic [BURST_W-1:0] cfg_bursts,
  output logic               launch,
  output logic               run_read,
  output logic               busy,
  output logic               end_flag,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_last,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               rd_valid
);

  localparam logic [BEAT_W-1:0]  BEAT_ONE  = BEAT_W'(1);
  localparam logic [BURST_W-1:0] BURST_ONE = BURST_W'(1);

  state_e             state;
  logic               mode_q;
  logic               read_q;
  logic [BEAT_W-1:0]  beats_q;
  logic [BEAT_W-1:0]  beats_left;
  logic [BURST_W-1:0] bursts_left;
  logic [ADDR_W-1:0]  addr_q;
  logic [OUT_W-1:0]   outst;
  logic               end_q;
  logic               issue_ok;
  logic               accept;

  assign launch    = (state == ST_IDLE) && start;
  assign issue_ok  = !(read_q && !mode_q && outst != '0);
  assign mem_valid = (state == ST_ISSUE) && issue_ok;
  assign accept    = mem_valid && mem_ready;
  assign mem_last  = !mode_q || (beats_left == BEAT_ONE);
  assign mem_addr  = addr_q;
  assign run_read  = read_q;
  assign busy      = (state != ST_IDLE);
  assign end_flag  = end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_q      <= 1'b0;
      read_q      <= 1'b0;
      beats_q     <= BEAT_ONE;
      beats_left  <= BEAT_ONE;
      bursts_left <= '0;
      addr_q      <= '0;
      end_q       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          mode_q      <= cfg_burst_mode;
          read_q      <= cfg_read;
          beats_q     <= (cfg_max_beats == '0) ? BEAT_ONE : cfg_max_beats;
          beats_left  <= (cfg_max_beats == '0) ? BEAT_ONE : cfg_max_beats;
          bursts_left <= cfg_bursts;
          addr_q      <= '0;
          end_q       <= 1'b0;
          state       <= (cfg_bursts == '0) ? ST_DRAIN : ST_ISSUE;
        end
        ST_ISSUE: if (accept) begin
          addr_q <= addr_q + ADDR_W'(1);
          if (beats_left == BEAT_ONE) begin
            beats_left  <= beats_q;
            bursts_left <= bursts_left - BURST_ONE;
            if (bursts_left == BURST_ONE) state <= ST_DRAIN;
          end else begin
            beats_left <= beats_left - BEAT_ONE;
          end
        end
        ST_DRAIN: if (outst == '0) begin
          state <= ST_IDLE;
          end_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else case ({accept && read_q, rd_valid})
      2'b10:   outst <= outst + OUT_W'(1);
      2'b01:   outst <= outst - OUT_W'(1);
      default: outst <= outst;
    endcase
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_last)));

  assert_single_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && read_q && !mode_q) |-> (outst == '0));

  assert_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && read_q) |-> (outst != '1));

  assert_return_owed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (outst != '0));

  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> !busy);

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine #(
  parameter int ADDR_W = 28,
  parameter int ERR_W  = 31,
  parameter int OUT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_burst_mode,
  input  logic              cfg_read,
  input  logic [1:0]        cfg_pattern,
  input  logic [7:0]        cfg_max_beats,
  input  logic [15:0]       cfg_bursts_lo,
  input  logic [15:0]       cfg_bursts_hi,
  input  logic              start,
  output logic              busy,
  output logic              end_flag,
  output logic [15:0]       err_cnt_lo,
  output logic [14:0]       err_cnt_hi,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_last,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data
);

  localparam int BEAT_W  = 8;
  localparam int BURST_W = 32;

  logic             launch;
  logic             run_read;
  logic [31:0]      words [2];
  logic [1:0]       adv;
  logic [ERR_W-1:0] err_q;
  logic [30:0]      err_full;

  memtest_seq #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BURST_W(BURST_W), .OUT_W(OUT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_burst_mode(cfg_burst_mode), .cfg_read(cfg_read),
    .cfg_max_beats(cfg_max_beats), .cfg_bursts({cfg_bursts_hi, cfg_bursts_lo}),
    .launch(launch), .run_read(run_read), .busy(busy), .end_flag(end_flag),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_last(mem_last),
    .mem_addr(mem_addr), .rd_valid(rd_valid)
  );

  // Slot 0 follows accepted commands, slot 1 follows returned read data.
  assign adv[0] = mem_valid && mem_ready;
  assign adv[1] = rd_valid;

  for (genvar g = 0; g < 2; g++) begin : g_pat
    memtest_pattern u_pat (
      .clk(clk), .rst_n(rst_n), .load(launch), .sel_in(cfg_pattern),
      .adv(adv[g]), .word(words[g])
    );
  end

  memtest_errcnt #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(launch), .sample(rd_valid && run_read),
    .actual(rd_data), .expected(words[1]), .count(err_q)
  );

  assign mem_write  = !run_read;
  assign mem_wdata  = words[0];
  assign err_full   = 31'(err_q);
  assign err_cnt_lo = err_full[15:0];
  assign err_cnt_hi = err_full[30:16];

  assert_end_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> !mem_valid);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!end_flag && err_full == '0));

endmodule

// File: tb/memtest_engine_test.sv
`timescale 1ns/1ps
module memtest_engine_test;
  localparam int ADDR_W = 28;
  localparam int ERR_W  = 3;
  localparam int RD_LAT = 3;
  localparam int MAXERR = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_burst_mode = 0, cfg_read = 0, start = 0;
  logic [1:0] cfg_pattern = 0;
  logic [7:0] cfg_max_beats = 0;
  logic [15:0] cfg_bursts_lo = 0, cfg_bursts_hi = 0;
  logic busy, end_flag, mem_valid, mem_write, mem_last;
  logic [15:0] err_cnt_lo;
  logic [14:0] err_cnt_hi;
  logic mem_ready = 0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic rd_valid;
  logic [31:0] rd_data;

  memtest_engine #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_mode(cfg_burst_mode), .cfg_read(cfg_read),
    .cfg_pattern(cfg_pattern), .cfg_max_beats(cfg_max_beats),
    .cfg_bursts_lo(cfg_bursts_lo), .cfg_bursts_hi(cfg_bursts_hi), .start(start),
    .busy(busy), .end_flag(end_flag), .err_cnt_lo(err_cnt_lo), .err_cnt_hi(err_cnt_hi),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_last(mem_last),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int total = 0, bad = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [1:0] p, input int unsigned i);
    case (p)
      2'd0: return 32'haaaa5555;
      2'd1: return 32'hffffffff;
      2'd2: return 32'ha5a55a5a;
      default: return i;
    endcase
  endfunction

  // memory model
  logic [31:0] mem [64];
  logic [RD_LAT-1:0] pv;
  logic [31:0] pd [RD_LAT];
  int corrupt_mode = 0;
  bit ready_rand = 0, ready_force = 1;
  logic [15:0] lfsr = 16'hace1;

  function automatic logic [31:0] corrupt(input logic [ADDR_W-1:0] a);
    if (corrupt_mode == 2) return 32'h1;
    if (corrupt_mode == 1 && (a % 3) == 0) return 32'h1;
    return 32'h0;
  endfunction

  initial for (int i = 0; i < 64; i++) mem[i] = 32'h0;

  always @(posedge clk) begin
    if (!rst_n) pv <= '0;
    else begin
      pv <= {pv[RD_LAT-2:0], mem_valid && mem_ready && !mem_write};
      pd[0] <= mem[mem_addr[5:0]] ^ corrupt(mem_addr);
      for (int i = 1; i < RD_LAT; i++) pd[i] <= pd[i-1];
      if (mem_valid && mem_ready && mem_write) mem[mem_addr[5:0]] <= mem_wdata;
    end
  end
  assign rd_valid = pv[RD_LAT-1];
  assign rd_data  = pd[RD_LAT-1];

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= ready_rand ? lfsr[0] : ready_force;
  end

  // command monitor
  int unsigned acc_cnt = 0;
  int mon_err = 0;
  int inflight = 0;
  bit exp_mode = 0, exp_rd = 0;
  logic [1:0] exp_pat = 0;
  int unsigned exp_beats = 1;

  always @(posedge clk) begin
    if (rst_n) begin
      if (rd_valid) inflight--;
      if (mem_valid && mem_ready) begin
        if (mem_addr != ADDR_W'(acc_cnt)) mon_err++;                    // R3
        if (mem_write != !exp_rd) mon_err++;                             // R3
        if (mem_write && mem_wdata != exp_word(exp_pat, acc_cnt)) mon_err++; // R4
        if (mem_last != (!exp_mode || (acc_cnt % exp_beats) == exp_beats - 1)) mon_err++; // R6
        if (!mem_write && !exp_mode && inflight != 0) mon_err++;          // R7
        if (!mem_write) inflight++;
        acc_cnt++;
      end
    end
  end

  task automatic launch(input bit mode, input bit rd, input logic [1:0] pat,
                        input logic [7:0] beats, input logic [31:0] bursts, input int cm);
    @(negedge clk);
    cfg_burst_mode = mode; cfg_read = rd; cfg_pattern = pat; cfg_max_beats = beats;
    cfg_bursts_lo = bursts[15:0]; cfg_bursts_hi = bursts[31:16];
    exp_mode = mode; exp_rd = rd; exp_pat = pat; exp_beats = (beats == 0) ? 1 : beats;
    acc_cnt = 0; mon_err = 0; corrupt_mode = cm;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end(input string req);
    int t = 0;
    while (!end_flag && t < 150000) begin @(negedge clk); t++; end
    chk(end_flag === 1'b1, req, end_flag, 1);
  endtask

  task automatic run(input bit mode, input bit rd, input logic [1:0] pat,
                     input logic [7:0] beats, input logic [31:0] bursts, input int cm,
                     input string req);
    launch(mode, rd, pat, beats, bursts, cm);
    wait_end(req);
  endtask

  initial begin
    while (cycles < 190000) begin @(posedge clk); cycles++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && end_flag == 0 && mem_valid == 0, "R1", {busy, end_flag, mem_valid}, 0);
    chk(err_cnt_lo == 0 && err_cnt_hi == 0, "R1", err_cnt_lo, 0);

    // R3 R4 R6 R7 R9: sweep modes and patterns, write then read
    ready_rand = 1;
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4; p++) begin
        run(m[0], 0, p[1:0], 8'd4, 32'd3, 0, "R11");
        chk(acc_cnt == 12, "R5", acc_cnt, 12);
        chk(mon_err == 0, "R4", mon_err, 0);
        run(m[0], 1, p[1:0], 8'd4, 32'd3, 0, "R11");
        chk(acc_cnt == 12, "R5", acc_cnt, 12);
        chk(mon_err == 0, "R7", mon_err, 0);
        chk(err_cnt_lo == 0, "R9", err_cnt_lo, 0);
        chk(busy == 0, "R11", busy, 0);
      end
    end

    // R9: corrupt every third address, 10 words
    run(1, 0, 2'd2, 8'd5, 32'd2, 0, "R11");
    run(1, 1, 2'd2, 8'd5, 32'd2, 1, "R11");
    chk(err_cnt_lo == 4, "R9", err_cnt_lo, 4);
    run(0, 1, 2'd2, 8'd5, 32'd2, 1, "R11");
    chk(err_cnt_lo == 4, "R9", err_cnt_lo, 4);

    // R10: saturation at 7 with 20 bad words
    run(1, 0, 2'd1, 8'd4, 32'd5, 0, "R11");
    run(1, 1, 2'd1, 8'd4, 32'd5, 2, "R11");
    chk(err_cnt_lo == MAXERR, "R10", err_cnt_lo, MAXERR);
    chk(err_cnt_hi == 0, "R10", err_cnt_hi, 0);

    // R2: start clears error count and end flag on the next cycle
    launch(1, 1, 2'd1, 8'd4, 32'd5, 0);
    chk(end_flag == 0 && busy == 1, "R2", {end_flag, busy}, 1);
    chk(err_cnt_lo == 0, "R2", err_cnt_lo, 0);
    wait_end("R11");
    chk(err_cnt_lo == 0, "R9", err_cnt_lo, 0);

    // R5 R6: beat count 0 acts as 1
    run(1, 0, 2'd3, 8'd0, 32'd6, 0, "R11");
    chk(acc_cnt == 6, "R5", acc_cnt, 6);
    chk(mon_err == 0, "R6", mon_err, 0);

    // R5: zero bursts
    run(1, 0, 2'd0, 8'd4, 32'd0, 0, "R5");
    chk(acc_cnt == 0, "R5", acc_cnt, 0);

    // R2: start and config change while busy are ignored
    ready_rand = 0; ready_force = 0;
    launch(1, 0, 2'd0, 8'd4, 32'd3, 0);
    repeat (3) @(negedge clk);
    cfg_read = 1; cfg_pattern = 2'd3; cfg_bursts_lo = 1; cfg_max_beats = 8'd1; start = 1;
    @(negedge clk);
    start = 0;
    ready_force = 1;
    wait_end("R2");
    chk(acc_cnt == 12, "R2", acc_cnt, 12);
    chk(mon_err == 0, "R2", mon_err, 0);

    // R5: burst count using the high half
    run(0, 0, 2'd1, 8'd1, {16'd1, 16'd2}, 0, "R5");
    chk(acc_cnt == 65538, "R5", acc_cnt, 65538);
    chk(mon_err == 0, "R3", mon_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule